// File: doc/BRIEF.md
# Store-and-Forward Packet Length Stamper

This block sits in a packet stream whose source knows nothing about packet sizes. It takes each incoming packet and holds every beat in a local beat buffer. While it does so it adds up the valid bytes that the byte strobes mark. When the closing beat arrives, it pushes a metadata record into a small queue. The record holds the byte count, the source and destination port masks taken from the opening beat, and an error flag. The flag is set if any beat of the packet carried an error indication.

The output side starts a packet only once that packet's metadata record is in the queue. It then replays the beats unchanged. On the opening output beat it presents the byte count, the source mask and the destination mask as sideband fields. These fields move with the data handshake exactly as if they were extra data bits, and they have no ready of their own. The error flag is driven on every beat of a failed packet. Downstream logic can therefore rely on a length that is known up front, at the cost of one full packet of latency.

A packet must not be longer than the beat buffer. Both buffer depths must be powers of two.

Top module: `pkt_len_stamper`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: Every accepted beat is replayed in order, with identical `out_data`, `out_strb` and `out_last`. Every non-closing output beat has all strobe bits high.
- R3: On the opening output beat, `out_len` equals the packet's byte count. For a packet of N beats whose closing beat has T strobe bits set (the low T bits), the count is (N-1) x (DATA_W/8) + T.
- R4: `out_src` and `out_dst` on the opening output beat equal `in_src` and `in_dst` as accepted on the opening input beat. Values present on those inputs during later beats have no effect.
- R5: If `in_err` is high on any accepted beat of a packet, `out_err` is high on every output beat of that packet. For a packet with no such beat, `out_err` is low throughout.
- R6: No beat of a packet is offered (`out_valid` stays low) until that packet's closing beat has been accepted at the input.
- R7: `in_ready` is low whenever the beat buffer is full or the metadata queue is full.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and all output fields stay unchanged in the next cycle.
- R9: On output beats other than the opening beat, `out_len`, `out_src` and `out_dst` are driven to zero.
- R10: Packets of a single beat and packets exactly `BUF_DEPTH` beats long both pass, with correct length and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high together with `in_valid` |
| in_data | input | DATA_W | Input beat payload |
| in_strb | input | DATA_W/8 | Input byte strobes, low bits contiguous, partial only on closing beat |
| in_last | input | 1 | Closing beat of the packet |
| in_src | input | PORT_W | Source port mask, sampled on opening beat |
| in_dst | input | PORT_W | Destination port mask, sampled on opening beat |
| in_err | input | 1 | Error indication for the packet this beat belongs to |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts output beat |
| out_data | output | DATA_W | Output beat payload |
| out_strb | output | DATA_W/8 | Output byte strobes |
| out_last | output | 1 | Closing output beat |
| out_len | output | LEN_W | Packet byte count, opening beat only |
| out_src | output | PORT_W | Source port mask, opening beat only |
| out_dst | output | PORT_W | Destination port mask, opening beat only |
| out_err | output | 1 | Packet failed validation, all beats |

## Verification
The bound checker covers the properties that can be seen cycle by cycle. These are: the ready gating against both full conditions, no write into a full buffer, no output offered without a queued metadata record, hold under backpressure, full strobes on non-closing beats, a nonzero length on opening beats, and zeroed sidebands on later beats. The correctness of the byte count, of the port masks taken from the opening beat, and of the error spreading to every beat of a failed packet can only be shown by the bench. Its scoreboard compares each replayed beat with the packet that was sent. The bench also shows that output is withheld while a packet is still incomplete, by pausing before a closing beat.

// File: rtl/plst_pkg.sv
package plst_pkg;
    // Position within a packet, shared by the ingress counter and the egress valve
    typedef enum logic {
        PH_OPEN = 1'b0,
        PH_BODY = 1'b1
    } phase_e;
endpackage

// File: rtl/plst_fifo.sv
module plst_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int PW = AW + 1;

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
    } ptr_t;

    ptr_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];

    always_comb begin
        st_d = st_q;
        if (push) st_d.wp = st_q.wp + PW'(1);
        if (pop)  st_d.rp = st_q.rp + PW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem[st_q.wp[AW-1:0]] <= wdata;
    end

    assign rdata = mem[st_q.rp[AW-1:0]];
    assign empty = (st_q.wp == st_q.rp);
    assign full  = (st_q.wp[AW] != st_q.rp[AW]) &&
                   (st_q.wp[AW-1:0] == st_q.rp[AW-1:0]);
endmodule

// File: rtl/plst_ingress.sv
module plst_ingress
    import plst_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LEN_W  = 16,
    parameter int PORT_W = 8,
    localparam int STRB_W = DATA_W / 8,
    localparam int MW     = LEN_W + 2 * PORT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic              last,
    input  logic [STRB_W-1:0] strb,
    input  logic [PORT_W-1:0] src,
    input  logic [PORT_W-1:0] dst,
    input  logic              err,
    output logic [MW-1:0]     meta
);
    typedef struct packed {
        phase_e            phase;
        logic [LEN_W-1:0]  len;
        logic [PORT_W-1:0] src;
        logic [PORT_W-1:0] dst;
        logic              err;
    } acc_t;

    acc_t st_d, st_q;
    logic [LEN_W-1:0]  cur_len;
    logic [PORT_W-1:0] cur_src;
    logic [PORT_W-1:0] cur_dst;
    logic              cur_err;
    logic              opening;

    always_comb begin
        opening = (st_q.phase == PH_OPEN);
        cur_len = (opening ? '0 : st_q.len) + LEN_W'($countones(strb));
        cur_src = opening ? src : st_q.src;
        cur_dst = opening ? dst : st_q.dst;
        cur_err = (!opening && st_q.err) || err;

        st_d = st_q;
        if (fire) begin
            if (last) begin
                st_d = '0;
                st_d.phase = PH_OPEN;
            end else begin
                st_d.phase = PH_BODY;
                st_d.len   = cur_len;
                st_d.src   = cur_src;
                st_d.dst   = cur_dst;
                st_d.err   = cur_err;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_OPEN;
        end else begin
            st_q <= st_d;
        end
    end

    assign meta = {cur_len, cur_src, cur_dst, cur_err};
endmodule

// File: rtl/plst_valve.sv
module plst_valve
    import plst_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LEN_W  = 16,
    parameter int PORT_W = 8,
    localparam int STRB_W = DATA_W / 8,
    localparam int BW     = DATA_W + STRB_W + 1,
    localparam int MW     = LEN_W + 2 * PORT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BW-1:0]     beat,
    input  logic              beat_empty,
    input  logic [MW-1:0]     meta,
    input  logic              meta_empty,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [STRB_W-1:0] out_strb,
    output logic              out_last,
    output logic [LEN_W-1:0]  out_len,
    output logic [PORT_W-1:0] out_src,
    output logic [PORT_W-1:0] out_dst,
    output logic              out_err,
    output logic              beat_pop,
    output logic              meta_pop
);
    typedef struct packed {
        phase_e phase;
    } vlv_t;

    vlv_t st_d, st_q;
    logic fire;
    logic opening;

    always_comb begin
        out_valid = !beat_empty && !meta_empty;
        {out_data, out_strb, out_last} = beat;
        opening  = (st_q.phase == PH_OPEN);
        out_len  = opening ? meta[MW-1 -: LEN_W] : '0;
        out_src  = opening ? meta[2*PORT_W : PORT_W+1] : '0;
        out_dst  = opening ? meta[PORT_W : 1] : '0;
        out_err  = meta[0];
        fire     = out_valid && out_ready;
        beat_pop = fire;
        meta_pop = fire && out_last;

        st_d = st_q;
        if (fire) st_d.phase = out_last ? PH_OPEN : PH_BODY;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.phase <= PH_OPEN;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pkt_len_stamper.sv
module pkt_len_stamper #(
    parameter int DATA_W    = 64,
    parameter int LEN_W     = 16,
    parameter int PORT_W    = 8,
    parameter int BUF_DEPTH = 64,
    parameter int LQ_DEPTH  = 4,
    localparam int STRB_W   = DATA_W / 8,
    localparam int BW       = DATA_W + STRB_W + 1,
    localparam int MW       = LEN_W + 2 * PORT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic [STRB_W-1:0] in_strb,
    input  logic              in_last,
    input  logic [PORT_W-1:0] in_src,
    input  logic [PORT_W-1:0] in_dst,
    input  logic              in_err,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic [STRB_W-1:0] out_strb,
    output logic              out_last,
    output logic [LEN_W-1:0]  out_len,
    output logic [PORT_W-1:0] out_src,
    output logic [PORT_W-1:0] out_dst,
    output logic              out_err
);
    logic          buf_full, buf_empty, buf_push, buf_pop;
    logic          meta_full, meta_empty, meta_push, meta_pop;
    logic [BW-1:0] buf_rd;
    logic [MW-1:0] meta_wr, meta_rd;
    logic          in_fire;

    assign in_ready  = !buf_full && !meta_full;
    assign in_fire   = in_valid && in_ready;
    assign buf_push  = in_fire;
    assign meta_push = in_fire && in_last;

    plst_ingress #(
        .DATA_W(DATA_W), .LEN_W(LEN_W), .PORT_W(PORT_W)
    ) u_ingress (
        .clk(clk), .rst_n(rst_n), .fire(in_fire), .last(in_last),
        .strb(in_strb), .src(in_src), .dst(in_dst), .err(in_err),
        .meta(meta_wr)
    );

    plst_fifo #(.W(BW), .DEPTH(BUF_DEPTH)) u_beats (
        .clk(clk), .rst_n(rst_n), .push(buf_push),
        .wdata({in_data, in_strb, in_last}), .pop(buf_pop),
        .rdata(buf_rd), .full(buf_full), .empty(buf_empty)
    );

    plst_fifo #(.W(MW), .DEPTH(LQ_DEPTH)) u_meta (
        .clk(clk), .rst_n(rst_n), .push(meta_push), .wdata(meta_wr),
        .pop(meta_pop), .rdata(meta_rd), .full(meta_full), .empty(meta_empty)
    );

    plst_valve #(
        .DATA_W(DATA_W), .LEN_W(LEN_W), .PORT_W(PORT_W)
    ) u_valve (
        .clk(clk), .rst_n(rst_n), .beat(buf_rd), .beat_empty(buf_empty),
        .meta(meta_rd), .meta_empty(meta_empty), .out_ready(out_ready),
        .out_valid(out_valid), .out_data(out_data), .out_strb(out_strb),
        .out_last(out_last), .out_len(out_len), .out_src(out_src),
        .out_dst(out_dst), .out_err(out_err),
        .beat_pop(buf_pop), .meta_pop(meta_pop)
    );
endmodule

// File: rtl/plst_checker.sv
module plst_checker #(
    parameter int DATA_W = 64,
    parameter int LEN_W  = 16,
    parameter int PORT_W = 8,
    localparam int STRB_W = DATA_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic [STRB_W-1:0] out_strb,
    input logic              out_last,
    input logic [LEN_W-1:0]  out_len,
    input logic [PORT_W-1:0] out_src,
    input logic [PORT_W-1:0] out_dst,
    input logic              out_err,
    input logic              buf_full,
    input logic              buf_push,
    input logic              meta_full,
    input logic              meta_empty
);
    logic at_open;

    always_ff @(posedge clk) begin
        if (!rst_n)                      at_open <= 1'b1;
        else if (out_valid && out_ready) at_open <= out_last;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        buf_push |-> !buf_full); // R7
    AST_READY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full || meta_full) |-> !in_ready); // R7
    AST_WHOLE_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !meta_empty); // R6
    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
        $stable(out_strb) && $stable(out_last) && $stable(out_len) &&
        $stable(out_src) && $stable(out_dst) && $stable(out_err))); // R8
    AST_FULL_STRB: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |-> (&out_strb)); // R2
    AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && at_open) |-> (out_len != '0)); // R3
    AST_BODY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !at_open) |-> (out_len == '0 && out_src == '0 &&
        out_dst == '0)); // R9
endmodule

bind pkt_len_stamper plst_checker #(
    .DATA_W(DATA_W), .LEN_W(LEN_W), .PORT_W(PORT_W)
) u_checker (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_strb(out_strb),
    .out_last(out_last), .out_len(out_len), .out_src(out_src),
    .out_dst(out_dst), .out_err(out_err), .buf_full(buf_full),
    .buf_push(buf_push), .meta_full(meta_full), .meta_empty(meta_empty)
);

// File: tb/pkt_len_stamper_test.sv
`timescale 1ns/1ps
module pkt_len_stamper_test;
    localparam int DW = 32;
    localparam int SW = DW / 8;
    localparam int LW = 16;
    localparam int PW = 8;
    localparam int BD = 16;
    localparam int LD = 2;

    typedef struct packed {
        logic [DW-1:0] data;
        logic [SW-1:0] strb;
        logic          last;
        logic          first;
        logic [LW-1:0] len;
        logic [PW-1:0] src;
        logic [PW-1:0] dst;
        logic          err;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] in_data = '0;
    logic [SW-1:0] in_strb = '0;
    logic          in_last = 1'b0;
    logic [PW-1:0] in_src = '0;
    logic [PW-1:0] in_dst = '0;
    logic          in_err = 1'b0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [DW-1:0] out_data;
    logic [SW-1:0] out_strb;
    logic          out_last;
    logic [LW-1:0] out_len;
    logic [PW-1:0] out_src;
    logic [PW-1:0] out_dst;
    logic          out_err;

    int   checks = 0;
    int   errors = 0;
    int   pid = 0;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    pkt_len_stamper #(
        .DATA_W(DW), .LEN_W(LW), .PORT_W(PW), .BUF_DEPTH(BD), .LQ_DEPTH(LD)
    ) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_strb(in_strb), .in_last(in_last),
        .in_src(in_src), .in_dst(in_dst), .in_err(in_err),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_strb(out_strb), .out_last(out_last), .out_len(out_len),
        .out_src(out_src), .out_dst(out_dst), .out_err(out_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Driver: pushes the expected beats into the scoreboard, then drives them
    task automatic send_pkt(input int nb, input int tail, input logic [PW-1:0] s,
                            input logic [PW-1:0] d, input int errbeat,
                            input int hold);
        int   elen;
        bit   ok;
        exp_t e;
        elen = (nb - 1) * SW + tail;
        for (int b = 0; b < nb; b++) begin
            e.data  = {8'(pid), 8'(b), 16'hA5C3 ^ 16'(b * 7)};
            e.strb  = (b == nb - 1) ? SW'((1 << tail) - 1) : '1;
            e.last  = (b == nb - 1);
            e.first = (b == 0);
            e.len   = (b == 0) ? LW'(elen) : '0;
            e.src   = (b == 0) ? s : '0;
            e.dst   = (b == 0) ? d : '0;
            e.err   = (errbeat >= 0);
            sb.push_back(e);
            if (hold > 0 && b == nb - 1) begin
                in_valid = 1'b0;
                repeat (hold) @(posedge clk);
                @(negedge clk);
                check(out_valid == 1'b0, "R6", "valid before closing beat",
                      64'(out_valid), 64'(0));
                @(posedge clk); #1;
            end
            in_valid = 1'b1;
            in_data  = e.data;
            in_strb  = e.strb;
            in_last  = e.last;
            in_src   = (b == 0) ? s : ~s;   // later beats carry junk (R4)
            in_dst   = (b == 0) ? d : ~d;
            in_err   = (b == errbeat);
            do begin
                @(negedge clk);
                ok = in_ready;
                @(posedge clk); #1;
            end while (!ok);
        end
        in_valid = 1'b0;
        in_err   = 1'b0;
        pid++;
    endtask

    task automatic drain();
        while (sb.size() != 0) @(posedge clk);
        @(posedge clk); #1;
    endtask

    // Monitor: compares each accepted output beat with the scoreboard head
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (sb.size() == 0) begin
                check(1'b0, "R2", "unexpected beat", 64'(out_data), 64'(0));
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(out_data == e.data, "R2", "data", 64'(out_data), 64'(e.data));
                check(out_strb == e.strb && out_last == e.last, "R2", "strb/last",
                      64'({out_strb, out_last}), 64'({e.strb, e.last}));
                if (e.first) begin
                    check(out_len == e.len, "R3", "length", 64'(out_len), 64'(e.len));
                    check(out_src == e.src && out_dst == e.dst, "R4", "port masks",
                          64'({out_src, out_dst}), 64'({e.src, e.dst}));
                end else begin
                    check(out_len == '0 && out_src == '0 && out_dst == '0, "R9",
                          "body sidebands", 64'({out_len, out_src, out_dst}), 64'(0));
                end
                check(out_err == e.err, "R5", "error flag", 64'(out_err), 64'(e.err));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R2 actual=%0d expected=%0d", sb.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] held_data;
        logic [LW-1:0] held_len;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 64'(0));
        check(in_ready == 1'b1, "R1", "in_ready after reset", 64'(in_ready), 64'(1));
        @(posedge clk); #1;

        out_ready = 1'b1;
        send_pkt(1, 3, 8'h01, 8'h80, -1, 0);   // R10 single beat
        send_pkt(4, 4, 8'h02, 8'h40, -1, 0);   // R3 full tail
        send_pkt(5, 1, 8'h10, 8'h03, 2, 0);    // R5 error mid packet
        send_pkt(3, 2, 8'h20, 8'h0C, 0, 0);    // R5 error on opening beat
        send_pkt(BD, 2, 8'h04, 8'h08, -1, 0);  // R10 maximum length
        drain();

        send_pkt(3, 4, 8'h05, 8'h50, -1, 4);   // R6 pause before closing beat
        drain();

        out_ready = 1'b0;                       // R7 metadata queue full
        send_pkt(1, 2, 8'h11, 8'h22, -1, 0);
        send_pkt(1, 1, 8'h33, 8'h44, 0, 0);
        @(negedge clk);
        check(in_ready == 1'b0, "R7", "ready with queue full", 64'(in_ready), 64'(0));
        held_data = out_data;
        held_len  = out_len;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b1 && out_data == held_data && out_len == held_len,
              "R8", "stall hold", 64'({out_valid, out_data}), 64'({1'b1, held_data}));
        @(posedge clk); #1;
        out_ready = 1'b1;
        drain();

        out_ready = 1'b0;                       // R7 beat buffer full
        send_pkt(BD, 3, 8'h66, 8'h77, -1, 0);
        @(negedge clk);
        check(in_ready == 1'b0, "R7", "ready with buffer full", 64'(in_ready), 64'(0));
        @(posedge clk); #1;
        out_ready = 1'b1;
        drain();

        fork
            begin
                for (int i = 0; i < 300; i++) begin
                    @(posedge clk); #1;
                    out_ready = (i % 3) != 0;
                end
                out_ready = 1'b1;
            end
        join_none
        for (int p = 0; p < 6; p++)
            send_pkt(1 + (p * 5) % BD, 1 + p % SW, 8'(1 << p), 8'(8'h80 >> p),
                     (p % 2 == 0) ? p % 3 : -1, 0);
        drain();
        repeat (320) @(posedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule